// File: doc/BRIEF.md
# DMA Common Register Slave with Access-Error Interrupts

This block is the shared register slave of a six-channel DMA controller. Software reaches it over a simple 64-bit register bus with one access per cycle. Through it, software sets the global DMA enable and the global interrupt enable, and starts a soft reset that clears itself. It also turns channels on and off through a channel register. In that register, each enable bit is guarded by a companion write-enable bit in the same word. A channel's enable bit also drops when that channel's datapath reports that its transfer is done.

Every bus access is classified. Misuse falls into one of five error sources: a misaligned address, a write to a read-only register, a read of a write-only register, a write that targets a channel on hold, and an access to an unmapped slot. Each source has its own status-enable bit, signal-enable bit and write-one-to-clear bit. One interrupt line combines them.

Registers sit on 8-byte aligned offsets. 0x00 is the identity word (read-only). 0x08 is the global configuration. 0x10 is the channel enable register. 0x18 is the soft reset. 0x20 is the error status-enable register. 0x28 is the error signal-enable register. 0x30 is the error clear register (write-only). 0x38 is the error status register (read-only). Aligned offsets from 0x40 upward are unmapped. Error bit k has the same meaning in the status-enable, signal-enable, clear and status registers: bit 0 misaligned, bit 1 write to read-only, bit 2 read of write-only, bit 3 write on hold, bit 4 unmapped.

Top module: `dma_common_regs`

## Requirements
- R1: After reset, the identity word at 0x00 reads ID_VALUE, every other register reads 0, ch_run is 0 and irq is 0.
- R2: Global configuration at 0x08 holds the DMA enable in bit 0 and the interrupt enable in bit 1, and both read back. ch_run[i] is channel i's enable bit ANDed with the DMA enable.
- R3: At 0x10, bits [5:0] are the channel enables and bits [13:8] are their write-enables. A write changes enable i only when bit 8+i of the written data is 1. The write-enable bits always read 0.
- R4: A one-cycle ch_done[i] pulse clears enable i. If, in the same cycle, a write to 0x10 has write-enable i set, the write decides the bit.
- R5: Writing 1 to bit 0 of 0x18 starts a soft reset. The bit reads 1 for RST_CYCLES cycles and then clears by itself. During that time all other registers are held at their reset values and bus writes have no effect.
- R6: Each access raises at most one error source, chosen in this priority order: misaligned (addr[2:0] not 0, bit 0), then unmapped (bit 4), then write to 0x00 or 0x38 (bit 1), then read of 0x30 (bit 2), then hold (bit 3).
- R7: A write to 0x10 that sets write-enable i while ch_hold[i] is 1 raises the hold error, and the whole write is dropped.
- R8: An error status bit latches only if its status-enable bit is 1 when the error occurs.
- R9: Writing 1 to bit k of 0x30 clears status bit k, and writing 0 leaves it unchanged.
- R10: irq is 1 exactly when the interrupt enable is 1 and some status bit is set whose signal-enable bit is also 1.
- R11: A read returns bus_rvalid and bus_rdata one cycle later. An errored read returns 0, and an errored write changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_req | input | 1 | Access request, one access per cycle |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wdata | input | 64 | Write data |
| bus_rvalid | output | 1 | Read data valid, one cycle after a read |
| bus_rdata | output | 64 | Read data |
| ch_done | input | NCH | Per-channel transfer-done pulses |
| ch_hold | input | NCH | Per-channel hold levels |
| ch_run | output | NCH | Per-channel run levels |
| irq | output | 1 | Combined error interrupt |

## Verification
Two things can land on a channel enable bit in the same cycle: a done pulse from that channel and a software write to the channel register. A hold level can also coincide with a write that tries to change the held channel. The directed part drives a done pulse together with a write whose write-enable covers one pulsed channel but not another. It then reads the register back and expects the written value on the first channel and a cleared bit on the second. The random part sets done pulses, hold levels and register accesses independently in each cycle. Every cycle is judged against a bench-side model of the register state.

// File: rtl/dmacr_pkg.sv
package dmacr_pkg;

    localparam int DATA_W = 64;
    localparam int SLOT_N = 8;
    localparam int ERR_N  = 5;
    localparam int WE_LSB = 8;

    // error source positions, shared by status, enable, signal and clear words
    localparam int ERR_MISALIGN = 0;
    localparam int ERR_WR_RO    = 1;
    localparam int ERR_RD_WO    = 2;
    localparam int ERR_HOLD     = 3;
    localparam int ERR_UNDEF    = 4;

    typedef enum logic [2:0] {
        SLOT_ID   = 3'd0,
        SLOT_GCFG = 3'd1,
        SLOT_CHEN = 3'd2,
        SLOT_RST  = 3'd3,
        SLOT_STEN = 3'd4,
        SLOT_SGEN = 3'd5,
        SLOT_CLR  = 3'd6,
        SLOT_STAT = 3'd7
    } slot_e;

    typedef struct packed {
        logic             ok;
        logic             wr;
        slot_e            slot;
        logic [ERR_N-1:0] err;
    } acc_t;

    function automatic logic [ERR_N-1:0] err_bit(input int idx);
        return ERR_N'(1) << idx;
    endfunction

endpackage

// File: rtl/dmacr_decode.sv
module dmacr_decode
    import dmacr_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int NCH    = 6
) (
    input  logic              req,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [NCH-1:0]    we_bits,
    input  logic [NCH-1:0]    hold,
    output acc_t              acc
);

    localparam int SLOT_W = ADDR_W - 3;

    logic [SLOT_W-1:0] slot_idx;
    logic              misal;
    logic              unmapped;
    slot_e             slot;

    always_comb begin
        slot_idx = addr[ADDR_W-1:3];
        misal    = addr[2:0] != 3'd0;
        unmapped = (slot_idx >> 3) != '0;
        slot     = slot_e'(slot_idx[2:0]);

        acc.err = '0;
        if (req) begin
            if (misal)
                acc.err = err_bit(ERR_MISALIGN);
            else if (unmapped)
                acc.err = err_bit(ERR_UNDEF);
            else if (wr && (slot == SLOT_ID || slot == SLOT_STAT))
                acc.err = err_bit(ERR_WR_RO);
            else if (!wr && slot == SLOT_CLR)
                acc.err = err_bit(ERR_RD_WO);
            else if (wr && slot == SLOT_CHEN && (we_bits & hold) != '0)
                acc.err = err_bit(ERR_HOLD);
        end
        acc.ok   = req && (acc.err == '0);
        acc.wr   = wr;
        acc.slot = slot;
    end

endmodule

// File: rtl/dmacr_chan.sv
module dmacr_chan #(
    parameter int NCH = 6
) (
    input  logic           clk,
    input  logic           wipe,
    input  logic           wr_hit,
    input  logic [NCH-1:0] wr_val,
    input  logic [NCH-1:0] wr_sel,
    input  logic [NCH-1:0] done,
    output logic [NCH-1:0] en
);

    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        logic en_q;
        always_ff @(posedge clk) begin
            if (wipe)
                en_q <= 1'b0;
            else if (wr_hit && wr_sel[ch])
                en_q <= wr_val[ch];
            else if (done[ch])
                en_q <= 1'b0;
        end
        assign en[ch] = en_q;
    end

endmodule

// File: rtl/dmacr_err.sv
module dmacr_err
    import dmacr_pkg::*;
(
    input  logic             clk,
    input  logic             wipe,
    input  logic             sten_wr,
    input  logic             sgen_wr,
    input  logic             clr_wr,
    input  logic [ERR_N-1:0] wbits,
    input  logic [ERR_N-1:0] ev,
    input  logic             int_en,
    output logic [ERR_N-1:0] stat,
    output logic [ERR_N-1:0] sten,
    output logic [ERR_N-1:0] sgen,
    output logic             irq
);

    logic [ERR_N-1:0] clr_mask;

    assign clr_mask = clr_wr ? wbits : '0;

    always_ff @(posedge clk) begin
        if (wipe) begin
            stat <= '0;
            sten <= '0;
            sgen <= '0;
        end else begin
            if (sten_wr)
                sten <= wbits;
            if (sgen_wr)
                sgen <= wbits;
            stat <= (stat & ~clr_mask) | (ev & sten);
        end
    end

    assign irq = int_en && ((stat & sgen) != '0);

endmodule

// File: rtl/dma_common_regs.sv
module dma_common_regs
    import dmacr_pkg::*;
#(
    parameter int              ADDR_W     = 8,
    parameter int              NCH        = 6,
    parameter int              RST_CYCLES = 4,
    parameter logic [63:0]     ID_VALUE   = 64'h0000_0001_D3AC_0010
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_req,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [63:0]       bus_wdata,
    output logic              bus_rvalid,
    output logic [63:0]       bus_rdata,
    input  logic [NCH-1:0]    ch_done,
    input  logic [NCH-1:0]    ch_hold,
    output logic [NCH-1:0]    ch_run,
    output logic              irq
);

    localparam int CNT_W = $clog2(RST_CYCLES + 1);

    acc_t             acc;
    logic [CNT_W-1:0] rst_cnt;
    logic             busy;
    logic             wr_ok;
    logic             rst_start;
    logic             wipe;
    logic             dma_en;
    logic             int_en;
    logic [NCH-1:0]   chen;
    logic [ERR_N-1:0] stat;
    logic [ERR_N-1:0] sten;
    logic [ERR_N-1:0] sgen;
    logic [63:0]      rd_val;

    dmacr_decode #(.ADDR_W(ADDR_W), .NCH(NCH)) u_decode (
        .req     (bus_req),
        .wr      (bus_wr),
        .addr    (bus_addr),
        .we_bits (bus_wdata[WE_LSB +: NCH]),
        .hold    (ch_hold),
        .acc     (acc)
    );

    assign busy      = rst_cnt != '0;
    assign wr_ok     = acc.ok && acc.wr && !busy;
    assign rst_start = wr_ok && acc.slot == SLOT_RST && bus_wdata[0];
    assign wipe      = rst || busy || rst_start;

    always_ff @(posedge clk) begin
        if (rst)
            rst_cnt <= '0;
        else if (rst_start)
            rst_cnt <= CNT_W'(RST_CYCLES);
        else if (busy)
            rst_cnt <= rst_cnt - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (wipe) begin
            dma_en <= 1'b0;
            int_en <= 1'b0;
        end else if (wr_ok && acc.slot == SLOT_GCFG) begin
            dma_en <= bus_wdata[0];
            int_en <= bus_wdata[1];
        end
    end

    dmacr_chan #(.NCH(NCH)) u_chan (
        .clk    (clk),
        .wipe   (wipe),
        .wr_hit (wr_ok && acc.slot == SLOT_CHEN),
        .wr_val (bus_wdata[NCH-1:0]),
        .wr_sel (bus_wdata[WE_LSB +: NCH]),
        .done   (ch_done),
        .en     (chen)
    );

    dmacr_err u_err (
        .clk     (clk),
        .wipe    (wipe),
        .sten_wr (wr_ok && acc.slot == SLOT_STEN),
        .sgen_wr (wr_ok && acc.slot == SLOT_SGEN),
        .clr_wr  (wr_ok && acc.slot == SLOT_CLR),
        .wbits   (bus_wdata[ERR_N-1:0]),
        .ev      (acc.err),
        .int_en  (int_en),
        .stat    (stat),
        .sten    (sten),
        .sgen    (sgen),
        .irq     (irq)
    );

    always_comb begin
        rd_val = '0;
        unique case (acc.slot)
            SLOT_ID:   rd_val = ID_VALUE;
            SLOT_GCFG: rd_val = {62'd0, int_en, dma_en};
            SLOT_CHEN: rd_val = 64'(chen);
            SLOT_RST:  rd_val = {63'd0, busy};
            SLOT_STEN: rd_val = 64'(sten);
            SLOT_SGEN: rd_val = 64'(sgen);
            SLOT_CLR:  rd_val = '0;
            SLOT_STAT: rd_val = 64'(stat);
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rvalid <= 1'b0;
            bus_rdata  <= '0;
        end else begin
            bus_rvalid <= bus_req && !bus_wr;
            if (bus_req && !bus_wr)
                bus_rdata <= acc.ok ? rd_val : '0;
        end
    end

    assign ch_run = chen & {NCH{dma_en}};

endmodule

// File: rtl/dmacr_chk.sv
module dmacr_chk
    import dmacr_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int NCH    = 6
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_req,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [63:0]       bus_wdata,
    input logic [NCH-1:0]    ch_done,
    input logic [NCH-1:0]    ch_run,
    input logic              irq,
    input logic [NCH-1:0]    chen,
    input logic [ERR_N-1:0]  stat,
    input logic [ERR_N-1:0]  sten,
    input logic              busy,
    input logic              dma_en
);

    localparam logic [ADDR_W-1:0] CHEN_ADDR = ADDR_W'(8 * int'(SLOT_CHEN));
    localparam logic [ADDR_W-1:0] CLR_ADDR  = ADDR_W'(8 * int'(SLOT_CLR));

    p_run_gated_r2: assert property (@(posedge clk) disable iff (rst)
        (ch_run != '0) |-> (dma_en && (ch_run & ~chen) == '0));

    p_en_rise_r3: assert property (@(posedge clk) disable iff (rst)
        ((chen & ~$past(chen)) != '0) |-> $past(bus_req && bus_wr && bus_addr == CHEN_ADDR));

    p_done_clears_r4: assert property (@(posedge clk) disable iff (rst)
        (ch_done != '0 && !(bus_req && bus_wr && bus_addr == CHEN_ADDR))
        |=> ((chen & $past(ch_done)) == '0));

    p_reset_holds_r5: assert property (@(posedge clk) disable iff (rst)
        busy |-> (chen == '0 && stat == '0 && sten == '0 && !dma_en));

    p_status_gated_r8: assert property (@(posedge clk) disable iff (rst)
        ((stat & ~$past(stat) & ~$past(sten)) == '0));

    p_clear_w1c_r9: assert property (@(posedge clk) disable iff (rst)
        (bus_req && bus_wr && bus_addr == CLR_ADDR && !busy)
        |=> ((stat & $past(bus_wdata[ERR_N-1:0])) == '0));

    p_irq_source_r10: assert property (@(posedge clk) disable iff (rst)
        irq |-> (stat != '0));

endmodule

bind dma_common_regs dmacr_chk #(.ADDR_W(ADDR_W), .NCH(NCH)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_req   (bus_req),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .ch_done   (ch_done),
    .ch_run    (ch_run),
    .irq       (irq),
    .chen      (chen),
    .stat      (stat),
    .sten      (sten),
    .busy      (busy),
    .dma_en    (dma_en)
);

// File: tb/tb_dma_common_regs.sv
`timescale 1ns/1ps
module tb_dma_common_regs;

    localparam int          NCH  = 6;
    localparam int          AW   = 8;
    localparam int          RSTC = 4;
    localparam logic [63:0] IDV  = 64'h0000_0001_D3AC_0010;

    logic          clk = 1'b0;
    logic          rst;
    logic          bus_req, bus_wr;
    logic [AW-1:0] bus_addr;
    logic [63:0]   bus_wdata;
    logic          bus_rvalid;
    logic [63:0]   bus_rdata;
    logic [NCH-1:0] ch_done, ch_hold, ch_run;
    logic          irq;

    always #2 clk = ~clk;

    dma_common_regs #(.ADDR_W(AW), .NCH(NCH), .RST_CYCLES(RSTC), .ID_VALUE(IDV)) dut (
        .clk(clk), .rst(rst), .bus_req(bus_req), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rvalid(bus_rvalid), .bus_rdata(bus_rdata),
        .ch_done(ch_done), .ch_hold(ch_hold), .ch_run(ch_run), .irq(irq)
    );

    int checks = 0;
    int errors = 0;

    // bench model of the register state
    logic           m_dma, m_int;
    logic [NCH-1:0] m_chen;
    logic [4:0]     m_sten, m_sgen, m_stat;
    int             m_cnt;
    logic           e_rvalid;
    logic [63:0]    e_rdata;

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [4:0] f_err(input logic rq, input logic wr, input logic [AW-1:0] a,
                                         input logic [63:0] d, input logic [NCH-1:0] hd);
        int s;
        if (!rq) return 5'd0;
        s = int'(a >> 3);
        if (a[2:0] != 3'd0) return 5'b00001;
        if (s >= 8) return 5'b10000;
        if (wr && (s == 0 || s == 7)) return 5'b00010;
        if (!wr && s == 6) return 5'b00100;
        if (wr && s == 2 && (d[8 +: NCH] & hd) != '0) return 5'b01000;
        return 5'd0;
    endfunction

    function automatic logic [63:0] f_read(input logic [AW-1:0] a);
        case (int'(a >> 3))
            0: return IDV;
            1: return {62'd0, m_int, m_dma};
            2: return 64'(m_chen);
            3: return 64'(m_cnt != 0);
            4: return 64'(m_sten);
            5: return 64'(m_sgen);
            7: return 64'(m_stat);
            default: return 64'd0;
        endcase
    endfunction

    task automatic model_clear();
        m_dma = 0; m_int = 0; m_chen = '0; m_sten = '0; m_sgen = '0; m_stat = '0;
    endtask

    task automatic compare(input string tag);
        logic exp_irq;
        exp_irq = m_int && ((m_stat & m_sgen) != '0);
        check(ch_run === (m_chen & {NCH{m_dma}}), {tag, " ch_run"}, 64'(ch_run), 64'(m_chen & {NCH{m_dma}}));
        check(irq === exp_irq, {tag, " irq"}, 64'(irq), 64'(exp_irq));
        check(bus_rvalid === e_rvalid, {tag, " rvalid"}, 64'(bus_rvalid), 64'(e_rvalid));
        if (e_rvalid)
            check(bus_rdata === e_rdata, {tag, " rdata"}, bus_rdata, e_rdata);
    endtask

    // one cycle: drive at negedge, advance model, compare at next negedge
    task automatic cyc(input logic rq, input logic wr, input logic [AW-1:0] a, input logic [63:0] d,
                       input logic [NCH-1:0] dn, input logic [NCH-1:0] hd, input string tag);
        logic [4:0] ev;
        logic       acc_wr, busy;
        int         s;
        bus_req = rq; bus_wr = wr; bus_addr = a; bus_wdata = d; ch_done = dn; ch_hold = hd;
        ev     = f_err(rq, wr, a, d, hd);
        busy   = m_cnt != 0;
        acc_wr = rq && wr && ev == 5'd0 && !busy;
        s      = int'(a >> 3);
        e_rvalid = rq && !wr;
        if (rq && !wr) e_rdata = (ev == 5'd0) ? f_read(a) : 64'd0;
        for (int i = 0; i < NCH; i++) begin
            if (acc_wr && s == 2 && d[8+i]) m_chen[i] = d[i];
            else if (dn[i]) m_chen[i] = 1'b0;
        end
        m_stat = (m_stat & ~((acc_wr && s == 6) ? d[4:0] : 5'd0)) | (ev & m_sten);
        if (acc_wr && s == 1) begin m_dma = d[0]; m_int = d[1]; end
        if (acc_wr && s == 4) m_sten = d[4:0];
        if (acc_wr && s == 5) m_sgen = d[4:0];
        if (acc_wr && s == 3 && d[0]) begin model_clear(); m_cnt = RSTC; end
        else if (busy) begin model_clear(); m_cnt--; end
        @(negedge clk);
        compare(tag);
    endtask

    task automatic wr_reg(input logic [AW-1:0] a, input logic [63:0] d, input string tag);
        cyc(1'b1, 1'b1, a, d, '0, '0, tag);
    endtask

    task automatic rd_exp(input logic [AW-1:0] a, input logic [63:0] exp, input string tag);
        cyc(1'b1, 1'b0, a, 64'd0, '0, '0, tag);
        check(bus_rdata === exp, {tag, " directed read"}, bus_rdata, exp);
    endtask

    task automatic idle(input string tag);
        cyc(1'b0, 1'b0, '0, 64'd0, '0, '0, tag);
    endtask

    initial begin
        #(4ns * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int unsigned seed;
        seed = 32'd1234;
        void'($urandom(seed));
        rst = 1'b1;
        bus_req = 0; bus_wr = 0; bus_addr = '0; bus_wdata = '0; ch_done = '0; ch_hold = '0;
        model_clear(); m_cnt = 0; e_rvalid = 0; e_rdata = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        compare("R1 reset state");

        rd_exp(8'h00, IDV, "R1 identity");
        rd_exp(8'h08, 64'd0, "R1 gcfg");
        rd_exp(8'h10, 64'd0, "R1 chen");
        rd_exp(8'h38, 64'd0, "R1 status");

        wr_reg(8'h08, 64'd3, "R2 write gcfg");
        rd_exp(8'h08, 64'd3, "R2 gcfg readback");

        wr_reg(8'h10, 64'h3F, "R3 no write-enable");
        rd_exp(8'h10, 64'd0, "R3 unchanged");
        wr_reg(8'h10, 64'h0101, "R3 enable ch0");
        rd_exp(8'h10, 64'h01, "R3 only ch0, we reads 0");
        wr_reg(8'h10, 64'h3E3E, "R3 enable rest");
        rd_exp(8'h10, 64'h3F, "R3 all on");
        check(ch_run === 6'h3F, "R2 run follows enable", 64'(ch_run), 64'h3F);

        cyc(1'b0, 1'b0, '0, 64'd0, 6'b000010, '0, "R4 done ch1");
        rd_exp(8'h10, 64'h3D, "R4 ch1 cleared");
        cyc(1'b1, 1'b1, 8'h10, 64'h0101, 6'b000101, '0, "R4 done with write");
        rd_exp(8'h10, 64'h39, "R4 write wins ch0, done clears ch2");

        wr_reg(8'h20, 64'h1F, "R8 status enables");
        cyc(1'b1, 1'b1, 8'h10, 64'h0800, '0, 6'b001000, "R7 write on hold");
        rd_exp(8'h10, 64'h39, "R7 write dropped");
        rd_exp(8'h38, 64'h08, "R7 hold error latched");

        wr_reg(8'h30, 64'h00, "R9 clear with zero");
        rd_exp(8'h38, 64'h08, "R9 zero no effect");
        wr_reg(8'h30, 64'h08, "R9 clear bit3");
        rd_exp(8'h38, 64'h00, "R9 cleared");

        rd_exp(8'h09, 64'd0, "R11 misaligned read returns 0");
        wr_reg(8'h00, 64'h55, "R6 write identity");
        wr_reg(8'h38, 64'h55, "R6 write status");
        rd_exp(8'h30, 64'd0, "R6 read clear register");
        rd_exp(8'h40, 64'd0, "R6 unmapped read");
        rd_exp(8'h38, 64'h17, "R6 sources latched");
        wr_reg(8'h30, 64'h1F, "R9 clear all");
        rd_exp(8'h41, 64'd0, "R6 misaligned and unmapped");
        rd_exp(8'h38, 64'h01, "R6 misaligned has priority");

        wr_reg(8'h20, 64'h00, "R8 disable status");
        rd_exp(8'h40, 64'd0, "R8 unmapped while disabled");
        rd_exp(8'h38, 64'h01, "R8 not latched");

        check(irq === 1'b0, "R10 no signal enable", 64'(irq), 64'd0);
        wr_reg(8'h28, 64'h01, "R10 signal enable bit0");
        check(irq === 1'b1, "R10 irq raised", 64'(irq), 64'd1);
        wr_reg(8'h08, 64'h01, "R10 interrupt enable off");
        check(irq === 1'b0, "R10 irq gated", 64'(irq), 64'd0);
        wr_reg(8'h08, 64'h03, "R10 interrupt enable on");
        check(irq === 1'b1, "R10 irq back", 64'(irq), 64'd1);
        wr_reg(8'h0C, 64'h00, "R11 misaligned write");
        rd_exp(8'h08, 64'h03, "R11 errored write ignored");

        wr_reg(8'h18, 64'h01, "R5 start soft reset");
        rd_exp(8'h18, 64'h01, "R5 reset bit reads 1");
        wr_reg(8'h08, 64'h03, "R5 write during reset");
        idle("R5 wait");
        idle("R5 wait");
        rd_exp(8'h18, 64'h00, "R5 reset bit self-clears");
        rd_exp(8'h08, 64'h00, "R5 gcfg cleared, write ignored");
        rd_exp(8'h10, 64'h00, "R5 chen cleared");
        rd_exp(8'h20, 64'h00, "R5 status enables cleared");
        check(irq === 1'b0 && ch_run === '0, "R5 outputs quiet", {57'd0, irq, ch_run}, 64'd0);

        wr_reg(8'h20, 64'h1F, "R8 random setup");
        wr_reg(8'h28, 64'h1F, "R10 random setup");
        wr_reg(8'h08, 64'h03, "R2 random setup");
        for (int n = 0; n < 4000; n++) begin
            logic          rq, wr;
            logic [AW-1:0] a;
            logic [63:0]   d;
            int            pick, s;
            rq   = ($urandom % 4) != 0;
            wr   = $urandom % 2;
            pick = $urandom % 16;
            if (pick < 12) s = $urandom % 8;
            else s = 8 + ($urandom % 24);
            a = AW'(s * 8);
            if (pick == 15) a[2:0] = 3'($urandom % 7 + 1);
            d = {$urandom, $urandom};
            if (s == 3 && ($urandom % 8) != 0) d[0] = 1'b0;
            cyc(rq, wr, a, d, NCH'($urandom & $urandom), NCH'($urandom & $urandom & $urandom),
                "R11 random mix");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule